// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block closes out one transfer descriptor after its bus transaction. It takes the descriptor's 32-bit control/status word and 32-bit token word, and the outcome reported by the transaction issuer. The outcome is a result kind plus a returned byte count. From these it computes the rewritten control/status word, a disposition telling the schedule walker what to do next, and the interrupt causes the descriptor raised.

The token is also decoded without any register: PID, device address, endpoint and maximum packet length. The issuer can use these fields in the same cycle it presents the descriptor. The verdict is registered once, so it appears on the outputs one clock after `in_valid`. A two-stage synchronizer releases the internal reset, and `rst_n` asserts asynchronously.

Top module: `td_status_update`

## Requirements
- R1: Token decode is combinational. PID is bits 7:0, device address is bits 14:8 and endpoint is bits 18:15. Maximum length is (bits 31:21 + 1) taken modulo 2048, so a field of 0x7FF means zero bytes.
- R2: A descriptor presented with `in_valid` high at a rising edge produces `out_valid` high with its verdict after that same edge. With `in_valid` low, `out_valid` is low after the edge. The disposition codes are 0 = advance, 1 = skip and 3 = abort. Code 2 is never produced. After reset all outputs are zero.
- R3: If the active bit (bit 23) is clear, the word is returned unchanged with disposition skip and no flags.
- R4: An active descriptor whose PID is not IN (0x69), OUT (0xE1) or SETUP (0x2D) raises `out_perr`, gives disposition abort and leaves the word unchanged. It raises no other flag.
- R5: For an active descriptor with a legal PID, `out_ioc` equals its interrupt-on-complete bit (bit 24), whatever the result.
- R6: For an active descriptor with a legal PID, the isochronous-select bit (bit 25) clears active in the returned word for every result.
- R7: Result kind 0 means data. It writes (length-1) mod 2048 into bits 10:0, clears active and the NAK bit (bit 19), and advances. For IN the length is `in_count`. For OUT and SETUP the length is the maximum length and `in_count` is ignored.
- R8: An IN data result with `in_count` above the maximum, or result kind 3 (babble), sets babble (bit 20) and stall (bit 22), clears active and aborts.
- R9: An IN data result below the maximum with short-packet-detect (bit 29) set raises `out_short` and skips. Without bit 29 it advances.
- R10: Result kind 1 (stall) sets stall, clears active and skips.
- R11: Result kind 2 (NAK) for IN or OUT sets the NAK bit, keeps active and skips.
- R12: Result kinds 4 to 7 (no response or error), and a NAK on SETUP, set timeout (bit 18) and skip. A NAK on SETUP also sets the NAK bit. A non-zero error count (bits 28:27) is decremented; reaching zero clears active and raises `out_err`. A count of zero stays zero with active kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor and outcome present this cycle |
| in_ctrl | input | 32 | Control/status word of the descriptor |
| in_token | input | 32 | Token word of the descriptor |
| in_result | input | 3 | Outcome kind: 0 data, 1 stall, 2 NAK, 3 babble, 4-7 no response/error |
| in_count | input | 12 | Bytes returned by the transaction |
| tok_pid | output | 8 | Decoded PID |
| tok_addr | output | 7 | Decoded device address |
| tok_ep | output | 4 | Decoded endpoint |
| tok_maxlen | output | 11 | Decoded maximum length in bytes |
| out_valid | output | 1 | Verdict valid |
| out_ctrl | output | 32 | Rewritten control/status word |
| out_disp | output | 2 | Disposition: 0 advance, 1 skip, 3 abort |
| out_ioc | output | 1 | Interrupt-on-complete cause |
| out_short | output | 1 | Short-packet cause |
| out_err | output | 1 | Error-count-exhausted cause |
| out_perr | output | 1 | Process error (illegal PID) |

## Verification
The decoded token fields settle within the same cycle as the token, and the bench reads them a moment after driving it. Every verdict is due exactly one rising edge after the descriptor is accepted. The driver stamps each expected item with that due cycle. The monitor samples on the falling edge and compares only when the stamp matches the current cycle count. A verdict that is missing, late or unrequested counts as a miscompare. Idle gaps between vectors check that `out_valid` falls when no descriptor was accepted.

// File: rtl/td_pkg.sv
package td_pkg;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 11;
  localparam int CNT_W  = LEN_W + 1;
  localparam int ERR_W  = 2;
  localparam int RES_W  = 3;

  // control/status word bit positions
  localparam int CB_LEN_HI = LEN_W - 1;
  localparam int CB_TMO    = 18;
  localparam int CB_NAK    = 19;
  localparam int CB_BAB    = 20;
  localparam int CB_STL    = 22;
  localparam int CB_ACT    = 23;
  localparam int CB_IOC    = 24;
  localparam int CB_ISO    = 25;
  localparam int CB_ERR_LO = 27;
  localparam int CB_ERR_HI = CB_ERR_LO + ERR_W - 1;
  localparam int CB_SPD    = 29;

  // token word field positions
  localparam int TK_PID_LO = 0;
  localparam int TK_PID_W  = 8;
  localparam int TK_ADR_LO = 8;
  localparam int TK_ADR_W  = 7;
  localparam int TK_EP_LO  = 15;
  localparam int TK_EP_W   = 4;
  localparam int TK_LEN_LO = 21;

  localparam logic [TK_PID_W-1:0] PID_IN    = 8'h69;
  localparam logic [TK_PID_W-1:0] PID_OUT   = 8'hE1;
  localparam logic [TK_PID_W-1:0] PID_SETUP = 8'h2D;

  typedef enum logic [1:0] {
    DISP_ADVANCE = 2'd0,
    DISP_SKIP    = 2'd1,
    DISP_ABORT   = 2'd3
  } disp_e;

  localparam logic [RES_W-1:0] RES_DATA   = 3'd0;
  localparam logic [RES_W-1:0] RES_STALL  = 3'd1;
  localparam logic [RES_W-1:0] RES_NAK    = 3'd2;
  localparam logic [RES_W-1:0] RES_BABBLE = 3'd3;

  typedef struct packed {
    logic [WORD_W-1:0] ctrl;
    disp_e             disp;
    logic              ioc;
    logic              shrt;
    logic              err;
    logic              perr;
  } verdict_t;

endpackage

// File: rtl/td_reset_sync.sv
module td_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/td_token_decode.sv
module td_token_decode
  import td_pkg::*;
(
  input  logic [WORD_W-1:0]   token,
  output logic [TK_PID_W-1:0] pid,
  output logic [TK_ADR_W-1:0] dev_addr,
  output logic [TK_EP_W-1:0]  endpoint,
  output logic [LEN_W-1:0]    max_len,
  output logic                is_in,
  output logic                is_setup,
  output logic                pid_legal
);

  logic [LEN_W-1:0] len_field;
  logic             unused_tok_bits;

  assign pid       = token[TK_PID_LO +: TK_PID_W];
  assign dev_addr  = token[TK_ADR_LO +: TK_ADR_W];
  assign endpoint  = token[TK_EP_LO  +: TK_EP_W];
  assign len_field = token[TK_LEN_LO +: LEN_W];

  // n-1 encoding: all-ones wraps to zero bytes
  assign max_len = len_field + LEN_W'(1);

  assign is_in     = (pid == PID_IN);
  assign is_setup  = (pid == PID_SETUP);
  assign pid_legal = is_in || is_setup || (pid == PID_OUT);

  assign unused_tok_bits = ^token[TK_LEN_LO-1:TK_EP_LO+TK_EP_W];

endmodule

// File: rtl/td_outcome_eval.sv
module td_outcome_eval
  import td_pkg::*;
(
  input  logic [WORD_W-1:0] ctrl,
  input  logic [LEN_W-1:0]  max_len,
  input  logic              is_in,
  input  logic              is_setup,
  input  logic              pid_legal,
  input  logic [RES_W-1:0]  result,
  input  logic [CNT_W-1:0]  count,
  output verdict_t          verdict
);

  logic [LEN_W-1:0] eff_len;
  logic [LEN_W-1:0] len_code;
  logic             oversize;
  logic             undersize;
  logic [ERR_W-1:0] cnt_now;
  logic [ERR_W-1:0] cnt_dec;
  logic             retry;

  assign eff_len   = is_in ? count[LEN_W-1:0] : max_len;
  assign len_code  = eff_len - LEN_W'(1);
  assign oversize  = is_in && (count > {1'b0, max_len});
  assign undersize = is_in && (count < {1'b0, max_len});
  assign cnt_now   = ctrl[CB_ERR_HI:CB_ERR_LO];
  assign cnt_dec   = (cnt_now != '0) ? (cnt_now - ERR_W'(1)) : cnt_now;

  always_comb begin
    verdict      = '0;
    verdict.ctrl = ctrl;
    verdict.disp = DISP_SKIP;
    retry        = 1'b0;
    if (!ctrl[CB_ACT]) begin
      verdict.disp = DISP_SKIP;
    end else if (!pid_legal) begin
      verdict.perr = 1'b1;
      verdict.disp = DISP_ABORT;
    end else begin
      verdict.ioc = ctrl[CB_IOC];
      if (ctrl[CB_ISO]) begin
        verdict.ctrl[CB_ACT] = 1'b0;
      end
      case (result)
        RES_DATA: begin
          verdict.ctrl[CB_LEN_HI:0] = len_code;
          verdict.ctrl[CB_ACT]      = 1'b0;
          verdict.ctrl[CB_NAK]      = 1'b0;
          if (oversize) begin
            verdict.ctrl[CB_BAB] = 1'b1;
            verdict.ctrl[CB_STL] = 1'b1;
            verdict.disp         = DISP_ABORT;
          end else if (undersize && ctrl[CB_SPD]) begin
            verdict.shrt = 1'b1;
            verdict.disp = DISP_SKIP;
          end else begin
            verdict.disp = DISP_ADVANCE;
          end
        end
        RES_STALL: begin
          verdict.ctrl[CB_STL] = 1'b1;
          verdict.ctrl[CB_ACT] = 1'b0;
        end
        RES_BABBLE: begin
          verdict.ctrl[CB_BAB] = 1'b1;
          verdict.ctrl[CB_STL] = 1'b1;
          verdict.ctrl[CB_ACT] = 1'b0;
          verdict.disp         = DISP_ABORT;
        end
        RES_NAK: begin
          verdict.ctrl[CB_NAK] = 1'b1;
          retry                = is_setup;
        end
        default: begin
          retry = 1'b1;
        end
      endcase
      if (retry) begin
        verdict.ctrl[CB_TMO]              = 1'b1;
        verdict.ctrl[CB_ERR_HI:CB_ERR_LO] = cnt_dec;
        if ((cnt_now != '0) && (cnt_dec == '0)) begin
          verdict.ctrl[CB_ACT] = 1'b0;
          verdict.err          = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/td_verdict_reg.sv
module td_verdict_reg
  import td_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  verdict_t verdict_d,
  output logic     vld_q,
  output verdict_t verdict_q
);

  verdict_t verdict_nxt;

  always_comb begin
    verdict_nxt = verdict_q;
    if (en) begin
      verdict_nxt = verdict_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= 1'b0;
      verdict_q <= '0;
    end else begin
      vld_q     <= en;
      verdict_q <= verdict_nxt;
    end
  end

endmodule

// File: rtl/td_status_update.sv
module td_status_update
  import td_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [WORD_W-1:0]   in_ctrl,
  input  logic [WORD_W-1:0]   in_token,
  input  logic [RES_W-1:0]    in_result,
  input  logic [CNT_W-1:0]    in_count,
  output logic [TK_PID_W-1:0] tok_pid,
  output logic [TK_ADR_W-1:0] tok_addr,
  output logic [TK_EP_W-1:0]  tok_ep,
  output logic [LEN_W-1:0]    tok_maxlen,
  output logic                out_valid,
  output logic [WORD_W-1:0]   out_ctrl,
  output logic [1:0]          out_disp,
  output logic                out_ioc,
  output logic                out_short,
  output logic                out_err,
  output logic                out_perr
);

  logic     rst_sync_n;
  logic     is_in;
  logic     is_setup;
  logic     pid_legal;
  verdict_t verdict_d;
  verdict_t verdict_q;

  td_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  td_token_decode u_dec (
    .token     (in_token),
    .pid       (tok_pid),
    .dev_addr  (tok_addr),
    .endpoint  (tok_ep),
    .max_len   (tok_maxlen),
    .is_in     (is_in),
    .is_setup  (is_setup),
    .pid_legal (pid_legal)
  );

  td_outcome_eval u_eval (
    .ctrl      (in_ctrl),
    .max_len   (tok_maxlen),
    .is_in     (is_in),
    .is_setup  (is_setup),
    .pid_legal (pid_legal),
    .result    (in_result),
    .count     (in_count),
    .verdict   (verdict_d)
  );

  td_verdict_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (in_valid),
    .verdict_d (verdict_d),
    .vld_q     (out_valid),
    .verdict_q (verdict_q)
  );

  assign out_ctrl  = verdict_q.ctrl;
  assign out_disp  = verdict_q.disp;
  assign out_ioc   = verdict_q.ioc;
  assign out_short = verdict_q.shrt;
  assign out_err   = verdict_q.err;
  assign out_perr  = verdict_q.perr;

endmodule

// File: rtl/td_status_checker.sv
module td_status_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_ctrl,
  input logic [31:0] in_token,
  input logic        out_valid,
  input logic [31:0] out_ctrl,
  input logic [1:0]  out_disp,
  input logic        out_ioc,
  input logic        out_short,
  input logic        out_err,
  input logic        out_perr
);

  logic legal_pid;
  assign legal_pid = (in_token[7:0] == 8'h69) || (in_token[7:0] == 8'hE1) ||
                     (in_token[7:0] == 8'h2D);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_disp_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_disp != 2'd2));

  a_r3_inactive_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ctrl[23]) |=>
      (out_ctrl == $past(in_ctrl)) && (out_disp == 2'd1) &&
      !out_ioc && !out_short && !out_err && !out_perr);

  a_r4_badpid_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl[23] && !legal_pid) |=> out_perr && (out_disp == 2'd3));

  a_r5_ioc_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl[23] && legal_pid) |=> (out_ioc == $past(in_ctrl[24])));

  a_r7_advance_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_disp == 2'd0)) |-> (!out_ctrl[23] && !out_ctrl[19]));

  a_r8_abort_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_disp == 2'd3) && !out_perr) |->
      (out_ctrl[22] && out_ctrl[20] && !out_ctrl[23]));

  a_r9_short_skips: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_short) |-> (out_disp == 2'd1));

  a_r12_err_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |->
      (!out_ctrl[23] && out_ctrl[18] && (out_ctrl[28:27] == 2'd0)));

endmodule

bind td_status_update td_status_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_ctrl   (in_ctrl),
  .in_token  (in_token),
  .out_valid (out_valid),
  .out_ctrl  (out_ctrl),
  .out_disp  (out_disp),
  .out_ioc   (out_ioc),
  .out_short (out_short),
  .out_err   (out_err),
  .out_perr  (out_perr)
);

// File: tb/tb_td_status_update.sv
module tb_td_status_update;

  localparam int PIN = 'h69, POUT = 'hE1, PSET = 'h2D;
  localparam logic [31:0] ACT = 32'h0080_0000, IOC = 32'h0100_0000,
                          ISO = 32'h0200_0000, SPD = 32'h2000_0000,
                          NAKB = 32'h0008_0000;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_ctrl;
  logic [31:0] in_token;
  logic [2:0]  in_result;
  logic [11:0] in_count;
  logic [7:0]  tok_pid;
  logic [6:0]  tok_addr;
  logic [3:0]  tok_ep;
  logic [10:0] tok_maxlen;
  logic        out_valid;
  logic [31:0] out_ctrl;
  logic [1:0]  out_disp;
  logic        out_ioc, out_short, out_err, out_perr;

  td_status_update dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
    .in_token(in_token), .in_result(in_result), .in_count(in_count),
    .tok_pid(tok_pid), .tok_addr(tok_addr), .tok_ep(tok_ep),
    .tok_maxlen(tok_maxlen), .out_valid(out_valid), .out_ctrl(out_ctrl),
    .out_disp(out_disp), .out_ioc(out_ioc), .out_short(out_short),
    .out_err(out_err), .out_perr(out_perr)
  );

  typedef struct {
    logic [31:0] ctrl;
    logic [1:0]  disp;
    logic        ioc, shrt, err, perr;
    int          due;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  int   cyc      = 0;
  bit   done     = 0;
  int unsigned seed = 32'h1234_5678;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk_tok(int pid, int adr, int ep, int mx);
    logic [31:0] t;
    t        = '0;
    t[7:0]   = 8'(pid);
    t[14:8]  = 7'(adr);
    t[18:15] = 4'(ep);
    t[31:21] = 11'(mx - 1);
    return t;
  endfunction

  function automatic exp_t model(logic [31:0] c, logic [31:0] t, logic [2:0] r,
                                 logic [11:0] n);
    exp_t e;
    int mx, pid, ln, ec;
    e.ctrl = c; e.disp = 2'd1; e.ioc = 0; e.shrt = 0; e.err = 0; e.perr = 0;
    e.due = 0; e.tag = "";
    pid = int'(t[7:0]);
    mx  = (int'(t[31:21]) + 1) & 32'h7ff;
    if (!c[23]) return e;
    if (pid != PIN && pid != POUT && pid != PSET) begin
      e.perr = 1; e.disp = 2'd3; return e;
    end
    e.ioc = c[24];
    if (c[25]) e.ctrl[23] = 1'b0;
    if (r == 3'd0) begin
      ln = (pid == PIN) ? int'(n) : mx;
      e.ctrl[10:0] = 11'(ln - 1);
      e.ctrl[23] = 1'b0; e.ctrl[19] = 1'b0;
      if (pid == PIN && ln > mx) begin
        e.ctrl[20] = 1'b1; e.ctrl[22] = 1'b1; e.disp = 2'd3;
      end else if (pid == PIN && c[29] && ln < mx) begin
        e.shrt = 1;
      end else begin
        e.disp = 2'd0;
      end
    end else if (r == 3'd1) begin
      e.ctrl[22] = 1'b1; e.ctrl[23] = 1'b0;
    end else if (r == 3'd3) begin
      e.ctrl[20] = 1'b1; e.ctrl[22] = 1'b1; e.ctrl[23] = 1'b0; e.disp = 2'd3;
    end else begin
      if (r == 3'd2) begin
        e.ctrl[19] = 1'b1;
        if (pid != PSET) return e;
      end
      e.ctrl[18] = 1'b1;
      ec = int'(c[28:27]);
      if (ec != 0) begin
        ec = ec - 1;
        if (ec == 0) begin e.ctrl[23] = 1'b0; e.err = 1; end
      end
      e.ctrl[28:27] = 2'(ec);
    end
    return e;
  endfunction

  task automatic drive(logic [31:0] c, logic [31:0] t, logic [2:0] r,
                       logic [11:0] n, string tag);
    exp_t e;
    int mx;
    @(negedge clk);
    in_valid = 1'b1; in_ctrl = c; in_token = t; in_result = r; in_count = n;
    #1;
    mx = (int'(t[31:21]) + 1) & 32'h7ff;
    n_checks++;
    if (tok_pid != t[7:0] || tok_addr != t[14:8] || tok_ep != t[18:15] ||
        int'(tok_maxlen) != mx) begin
      n_fails++;
      $display("FAIL R1 decode: got pid=%h adr=%h ep=%h max=%0d exp pid=%h adr=%h ep=%h max=%0d",
               tok_pid, tok_addr, tok_ep, tok_maxlen, t[7:0], t[14:8], t[18:15], mx);
    end
    e = model(c, t, r, n);
    e.due = cyc + 1;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: one compare per verdict, on the falling edge after it is due
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        n_checks++;
        if (exp_q.size() == 0) begin
          n_fails++;
          $display("FAIL R2 unrequested verdict: got ctrl=%h exp none", out_ctrl);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.due != cyc || out_ctrl !== e.ctrl || out_disp !== e.disp ||
              out_ioc !== e.ioc || out_short !== e.shrt || out_err !== e.err ||
              out_perr !== e.perr) begin
            n_fails++;
            $display("FAIL %s: got cyc=%0d ctrl=%h disp=%0d ioc=%b sh=%b err=%b perr=%b exp cyc=%0d ctrl=%h disp=%0d ioc=%b sh=%b err=%b perr=%b",
                     e.tag, cyc, out_ctrl, out_disp, out_ioc, out_short, out_err, out_perr,
                     e.due, e.ctrl, e.disp, e.ioc, e.shrt, e.err, e.perr);
          end
        end
      end else if (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        n_fails++;
        $display("FAIL R2 missing verdict (%s): got out_valid=0 exp 1 at cyc %0d", e.tag, e.due);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got cyc=%0d exp completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  function automatic int unsigned nxt_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_ctrl = '0; in_token = '0;
    in_result = '0; in_count = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || out_ctrl !== 32'h0 || out_disp !== 2'd0 ||
        out_ioc || out_short || out_err || out_perr) begin
      n_fails++;
      $display("FAIL R2 reset state: got v=%b ctrl=%h disp=%0d exp all zero",
               out_valid, out_ctrl, out_disp);
    end

    drive(32'h0000_0123, mk_tok(PIN, 5, 2, 8), 3'd0, 12'd8, "R3 inactive");
    drive(ACT | IOC, mk_tok('hA5, 1, 1, 8), 3'd0, 12'd8, "R4 bad pid");
    drive(ACT | 32'h0000_0555, mk_tok(PIN, 3, 1, 8), 3'd0, 12'd8, "R7 IN full");
    idle();
    drive(ACT, mk_tok(POUT, 3, 1, 16), 3'd0, 12'd3, "R7 OUT count ignored");
    drive(ACT, mk_tok(PSET, 0, 0, 8), 3'd0, 12'd0, "R7 SETUP data");
    drive(ACT, mk_tok(PIN, 9, 4, 0), 3'd0, 12'd0, "R7 zero length");
    drive(ACT | NAKB, mk_tok(PIN, 9, 4, 4), 3'd0, 12'd4, "R7 NAK cleared");
    drive(ACT, mk_tok(PIN, 2, 2, 8), 3'd0, 12'd9, "R8 oversize");
    drive(ACT, mk_tok(POUT, 2, 2, 8), 3'd3, 12'd0, "R8 babble result");
    drive(ACT | SPD, mk_tok(PIN, 7, 3, 8), 3'd0, 12'd4, "R9 short SPD");
    drive(ACT, mk_tok(PIN, 7, 3, 8), 3'd0, 12'd4, "R9 short no SPD");
    drive(ACT, mk_tok(POUT, 7, 3, 8), 3'd1, 12'd0, "R10 stall");
    drive(ACT | IOC, mk_tok(PIN, 7, 3, 8), 3'd1, 12'd0, "R5 ioc on stall");
    drive(ACT | 32'h1800_0000, mk_tok(PIN, 1, 1, 8), 3'd2, 12'd0, "R11 NAK IN");
    drive(ACT | ISO, mk_tok(POUT, 1, 1, 8), 3'd2, 12'd0, "R6 iso NAK");
    drive(ACT | 32'h0800_0000, mk_tok(PSET, 1, 0, 8), 3'd2, 12'd0, "R12 NAK SETUP");
    drive(ACT | 32'h1800_0000, mk_tok(PIN, 1, 1, 8), 3'd4, 12'd0, "R12 count 3");
    drive(ACT, mk_tok(POUT, 1, 1, 8), 3'd7, 12'd0, "R12 count 0");
    idle();
    idle();

    for (int i = 0; i < 300; i++) begin
      int unsigned a, b;
      int pid;
      logic [31:0] c;
      a = nxt_rand(); b = nxt_rand();
      case (a % 5)
        0: pid = PIN; 1: pid = PIN; 2: pid = POUT; 3: pid = PSET;
        default: pid = int'(b[7:0]);
      endcase
      c = b & 32'h3BDF_FFFF;
      if (a[8]) c = c | ACT;
      drive(c, mk_tok(pid, int'(a[15:9]), int'(a[19:16]), int'(b[31:21]) + 1),
            3'(a[22:20]), 12'(a[31:23] % 24), "R12 mixed sweep");
      if (a[3:2] == 2'd0) idle();
    end
    idle();
    repeat (4) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fails++;
      $display("FAIL R2 leftover: got %0d pending exp 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule